// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the control side of a sigma-delta converter. A host shifts in a 16-bit control word over a serial link, MSB first. The word holds power, start and continuous-mode bits plus the converter settings: sample rate, gain, input swap, output coding and reference choice. From these the block issues filter-reset, conversion-start, abort and data-latch events to the converter. It also divides the system clock to make the conversion-cycle strobe, and keeps a result register with a done flag.

A start first needs a settling period of four conversion cycles. Only then is a valid result latched. The start bit reads back as pending until that first latch. After it, the sequencer goes idle (single mode) or latches a new result on every strobe (continuous mode). Clearing the continuous bit or the power bit stops a running sequence. The last result stays in the register and the settling state is discarded.

The state machine has three states:
- ST_IDLE: waits for a start.
- ST_SETTLE: counts the four settling strobes.
- ST_RUN: continuous latching.

Its transitions are:
- IDLE to SETTLE on a start write.
- SETTLE to SETTLE on a restart.
- SETTLE to IDLE on the fourth strobe in single mode, or on a stop.
- SETTLE to RUN on the fourth strobe in continuous mode.
- RUN to IDLE on a stop.
- RUN to SETTLE on a restart.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The word is taken as 16 bits on `ser_rise` pulses while `ser_frame` is high, MSB first. Its fields are [15] start, [14] continuous, [13] power, [12:10] rate, [9:8] gain, [7] swap, [6] bipolar, [5] reference; [4:0] are ignored. A word with start=1 and power=1 pulses `conv_start` and `filt_rst` in the cycle after the 16th bit and sets `busy`.
- R2: After a start, the first `data_latch` and the rise of `done` occur on the fourth `cyc_tick`. `done` is seen 4*divisor+1 cycles after the `conv_start` cycle.
- R3: `start_pend` is high from the start until the first result is latched, then clears by itself.
- R4: With continuous=0 at the start, exactly one result is latched and `busy` drops. Later changes of `conv_raw` do not reach `result`.
- R5: With continuous=1 at the start, a new result is latched on every `cyc_tick` after the first.
- R6: While running continuously, a word with start=0 and continuous=0 pulses `conv_abort` and clears `busy`. `result` and `done` keep their values.
- R7: A word with power=0 stops a running sequence with `conv_abort`. `cyc_tick` stays low while `pwr_on` is 0.
- R8: Setting continuous=1 with start=0 while idle issues no `conv_start` and leaves `busy` low.
- R9: A word with start=0 leaves `rate_sel`, `gain_mult`, `in_swap`, `bipolar` and `ref_sel` unchanged.
- R10: Gain codes 00, 01, 10 and 11 give `gain_mult` values 1, 2, 4 and 8.
- R11: `done` clears on an `rd_strobe` pulse or on a new start.
- R12: The strobe divisor is BASE_DIV shifted left by the rate code (4, 8, ... 512 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_frame | input | 1 | Serial frame active; low resets the bit count |
| ser_rise | input | 1 | One-cycle pulse per serial clock rising edge |
| ser_din | input | 1 | Serial data bit |
| rd_strobe | input | 1 | Result register read pulse |
| conv_raw | input | RES_W | Raw converter output |
| conv_start | output | 1 | Conversion start event |
| filt_rst | output | 1 | Filter state reset event |
| conv_abort | output | 1 | Sequence abort event |
| data_latch | output | 1 | Result capture event |
| cyc_tick | output | 1 | Conversion-cycle strobe |
| busy | output | 1 | Sequencer not idle |
| start_pend | output | 1 | Start bit readback |
| done | output | 1 | Result ready flag |
| result | output | RES_W | Result register |
| pwr_on | output | 1 | Power-enable bit |
| rate_sel | output | 3 | Active rate code |
| gain_mult | output | 4 | Active gain factor |
| in_swap | output | 1 | Swap differential inputs |
| bipolar | output | 1 | Two's-complement output coding |
| ref_sel | output | 1 | Alternate reference chosen |

## Verification
The hardest cases are stops that arrive mid-sequence. A continuous abort must come after the sequence has reached ST_RUN, and a power-off must come while strobes are still running. The bench reaches these by timing: it waits for the first `done` of a continuous start, counts whole divisor periods, and only then shifts in the stop word. It then changes `conv_raw` and watches `result`, `busy` and `cyc_tick` for many divisor periods. This proves the old result survives and no further latch happens.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic       start;
        logic       cont;
        logic       pwr;
        logic [2:0] rate;
        logic [1:0] gain;
        logic       swap;
        logic       bip;
        logic       refsel;
    } ctl_word_t;

    function automatic ctl_word_t decode_word(input logic [15:0] w);
        ctl_word_t c;
        c.start  = w[15];
        c.cont   = w[14];
        c.pwr    = w[13];
        c.rate   = w[12:10];
        c.gain   = w[9:8];
        c.swap   = w[7];
        c.bip    = w[6];
        c.refsel = w[5];
        return c;
    endfunction

endpackage

// File: rtl/adc_ser_rx.sv
module adc_ser_rx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame,
    input  logic              rise,
    input  logic              din,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            word_o   <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (!frame) begin
                bit_cnt <= '0;
            end else if (rise) begin
                shreg <= {shreg[WORD_W-2:0], din};
                if (bit_cnt == CNT_W'(WORD_W - 1)) begin
                    bit_cnt  <= '0;
                    word_o   <= {shreg[WORD_W-2:0], din};
                    word_vld <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_rate_div.sv
module adc_rate_div #(
    parameter int BASE_DIV = 4,
    parameter int RATE_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int MAX_DIV = BASE_DIV << ((1 << RATE_W) - 1);
    localparam int DIV_W   = $clog2(MAX_DIV + 1);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_lim;

    assign div_lim = DIV_W'(BASE_DIV) << rate;
    assign tick    = en && (cnt == div_lim - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clr || !en) cnt <= '0;
        else if (tick)       cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int SETTLE_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_vld,
    input  logic w_start,
    input  logic w_cont,
    input  logic w_pwr,
    input  logic tick,
    output logic busy,
    output logic conv_start,
    output logic conv_abort,
    output logic data_latch,
    output logic start_pend
);
    localparam int SC_W = $clog2(SETTLE_N + 1);

    seq_state_t state, state_nx;
    logic [SC_W-1:0] settle_cnt;
    logic run_cont;
    logic start_evt, stop_evt, settle_last;

    assign start_evt   = word_vld && w_start && w_pwr;
    assign stop_evt    = (state != ST_IDLE) && word_vld && !start_evt &&
                         (!w_pwr || (run_cont && !w_cont));
    assign settle_last = (state == ST_SETTLE) && tick &&
                         (settle_cnt == SC_W'(SETTLE_N - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start_evt) state_nx = ST_SETTLE;
            ST_SETTLE: begin
                if (start_evt)        state_nx = ST_SETTLE;
                else if (stop_evt)    state_nx = ST_IDLE;
                else if (settle_last) state_nx = run_cont ? ST_RUN : ST_IDLE;
            end
            ST_RUN: begin
                if (start_evt)     state_nx = ST_SETTLE;
                else if (stop_evt) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        conv_start = start_evt;
        conv_abort = stop_evt;
        data_latch = !start_evt && !stop_evt && tick &&
                     (settle_last || state == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_cnt <= '0;
            run_cont   <= 1'b0;
            start_pend <= 1'b0;
        end else begin
            if (start_evt) begin
                settle_cnt <= '0;
                run_cont   <= w_cont;
                start_pend <= 1'b1;
            end else begin
                if (state == ST_SETTLE && tick) settle_cnt <= settle_cnt + 1'b1;
                if (stop_evt || (settle_last && data_latch)) start_pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W    = 16,
    parameter int BASE_DIV = 4,
    parameter int SETTLE_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_frame,
    input  logic             ser_rise,
    input  logic             ser_din,
    input  logic             rd_strobe,
    input  logic [RES_W-1:0] conv_raw,
    output logic             conv_start,
    output logic             filt_rst,
    output logic             conv_abort,
    output logic             data_latch,
    output logic             cyc_tick,
    output logic             busy,
    output logic             start_pend,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic             pwr_on,
    output logic [2:0]       rate_sel,
    output logic [3:0]       gain_mult,
    output logic             in_swap,
    output logic             bipolar,
    output logic             ref_sel
);
    localparam int WORD_W = 16;

    logic [WORD_W-1:0] word;
    logic              word_vld;
    ctl_word_t         cw;
    logic [1:0]        gain_q;

    assign cw = decode_word(word);

    adc_ser_rx #(.WORD_W(WORD_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .frame(ser_frame), .rise(ser_rise),
        .din(ser_din), .word_o(word), .word_vld(word_vld)
    );

    adc_rate_div #(.BASE_DIV(BASE_DIV), .RATE_W(3)) div_i (
        .clk(clk), .rst_n(rst_n), .en(pwr_on), .clr(conv_start),
        .rate(rate_sel), .tick(cyc_tick)
    );

    adc_seq_fsm #(.SETTLE_N(SETTLE_N)) fsm_i (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .w_start(cw.start),
        .w_cont(cw.cont), .w_pwr(cw.pwr), .tick(cyc_tick), .busy(busy),
        .conv_start(conv_start), .conv_abort(conv_abort),
        .data_latch(data_latch), .start_pend(start_pend)
    );

    assign filt_rst  = conv_start;
    assign gain_mult = 4'd1 << gain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_on   <= 1'b0;
            rate_sel <= '0;
            gain_q   <= '0;
            in_swap  <= 1'b0;
            bipolar  <= 1'b0;
            ref_sel  <= 1'b0;
            result   <= '0;
            done     <= 1'b0;
        end else begin
            if (word_vld) begin
                pwr_on <= cw.pwr;
                if (cw.start) begin
                    rate_sel <= cw.rate;
                    gain_q   <= cw.gain;
                    in_swap  <= cw.swap;
                    bipolar  <= cw.bip;
                    ref_sel  <= cw.refsel;
                end
            end
            if (data_latch) begin
                result <= conv_raw;
                done   <= 1'b1;
            end else if (conv_start || rd_strobe) begin
                done <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int RES_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_start,
    input logic             conv_abort,
    input logic             data_latch,
    input logic             cyc_tick,
    input logic             busy,
    input logic             start_pend,
    input logic             done,
    input logic             rd_strobe,
    input logic             pwr_on,
    input logic [RES_W-1:0] result
);
    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> busy);
    // R2
    latch_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_latch |-> cyc_tick);
    // R3
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_latch && !conv_start) |=> !start_pend);
    // R4
    idle_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !data_latch);
    // R6
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |=> !busy);
    // R6
    abort_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |=> $stable(result));
    // R7
    no_tick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> !cyc_tick);
    // R11
    done_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !data_latch) |=> !done);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.RES_W(RES_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_abort(conv_abort),
    .data_latch(data_latch), .cyc_tick(cyc_tick), .busy(busy),
    .start_pend(start_pend), .done(done), .rd_strobe(rd_strobe),
    .pwr_on(pwr_on), .result(result)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
    localparam int RES_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_frame = 1'b0, ser_rise = 1'b0, ser_din = 1'b0, rd_strobe = 1'b0;
    logic [RES_W-1:0] conv_raw = '0;
    logic conv_start, filt_rst, conv_abort, data_latch, cyc_tick, busy;
    logic start_pend, done, pwr_on, in_swap, bipolar, ref_sel;
    logic [RES_W-1:0] result;
    logic [2:0] rate_sel;
    logic [3:0] gain_mult;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    adc_seq_ctrl #(.RES_W(RES_W), .BASE_DIV(4), .SETTLE_N(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .ser_frame(ser_frame), .ser_rise(ser_rise),
        .ser_din(ser_din), .rd_strobe(rd_strobe), .conv_raw(conv_raw),
        .conv_start(conv_start), .filt_rst(filt_rst), .conv_abort(conv_abort),
        .data_latch(data_latch), .cyc_tick(cyc_tick), .busy(busy),
        .start_pend(start_pend), .done(done), .result(result), .pwr_on(pwr_on),
        .rate_sel(rate_sel), .gain_mult(gain_mult), .in_swap(in_swap),
        .bipolar(bipolar), .ref_sel(ref_sel)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input bit st, input bit ct, input bit pw,
        input logic [2:0] rt, input logic [1:0] gn, input bit sw, input bit bp, input bit rf);
        return {st, ct, pw, rt, gn, sw, bp, rf, 5'b10101};
    endfunction

    // returns at the falling edge right after the 16th bit is captured
    task automatic write_word(input logic [15:0] w);
        ser_frame = 1'b1;
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            ser_din  = w[i];
            ser_rise = 1'b1;
            @(negedge clk);
            ser_rise = 1'b0;
        end
        ser_frame = 1'b0;
    endtask

    task automatic wait_done(output int k);
        k = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            k++;
            if (done) break;
        end
    endtask

    task automatic test_reset();
        check(!busy && !done && !start_pend && !pwr_on && result == 0, "R1 reset",
              {busy, done, start_pend, pwr_on}, 0);
        check(gain_mult == 4'd1, "R10 reset gain", gain_mult, 1);
    endtask

    task automatic test_single(input logic [2:0] rt, input int exp_lat);
        int k;
        conv_raw = 16'h1234 + 16'(rt);
        write_word(mk(1, 0, 1, rt, 2'b01, 1, 1, 0));
        check(conv_start && filt_rst, "R1 start pulse", conv_start, 1);
        @(negedge clk);
        k = 1;
        check(busy, "R1 busy", busy, 1);
        check(start_pend, "R3 pending", start_pend, 1);
        check(!done, "R11 start clears done", done, 0);
        begin
            int m;
            wait_done(m);
            k += m;
        end
        check(k == exp_lat, "R2/R12 latency", k, exp_lat);
        check(result == 16'h1234 + 16'(rt), "R2 result", result, 16'h1234 + rt);
        check(!start_pend, "R3 self clear", start_pend, 0);
        conv_raw = 16'hBEEF;
        repeat (3 * (4 << rt)) @(negedge clk);
        check(!busy, "R4 idle after one", busy, 0);
        check(result == 16'h1234 + 16'(rt), "R4 result held", result, 16'h1234 + rt);
        check(rate_sel == rt, "R12 rate", rate_sel, rt);
    endtask

    task automatic start_cont(input logic [2:0] rt);
        int m;
        conv_raw = 16'h0A0A;
        write_word(mk(1, 1, 1, rt, 2'b00, 0, 0, 0));
        wait_done(m);
    endtask

    task automatic test_cont_abort();
        start_cont(3'd1);
        check(result == 16'h0A0A, "R5 first", result, 16'h0A0A);
        conv_raw = 16'h0B0B;
        repeat (8) @(negedge clk);
        check(result == 16'h0B0B && busy, "R5 next latch", result, 16'h0B0B);
        conv_raw = 16'h0C0C;
        repeat (8) @(negedge clk);
        check(result == 16'h0C0C, "R5 third latch", result, 16'h0C0C);
        write_word(mk(0, 0, 1, 3'd1, 2'b00, 0, 0, 0));
        check(conv_abort, "R6 abort pulse", conv_abort, 1);
        begin
            logic [15:0] kept;
            @(negedge clk);
            kept = result;
            conv_raw = 16'h7777;
            repeat (60) @(negedge clk);
            check(!busy, "R6 idle", busy, 0);
            check(result == kept, "R6 result kept", result, kept);
            check(done, "R6 done kept", done, 1);
        end
    endtask

    task automatic test_power_off();
        int ticks = 0;
        start_cont(3'd0);
        write_word(mk(0, 1, 0, 3'd0, 2'b00, 0, 0, 0));
        check(conv_abort, "R7 abort on power off", conv_abort, 1);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (cyc_tick) ticks++;
        end
        check(ticks == 0, "R7 no ticks", ticks, 0);
        check(!busy && !pwr_on, "R7 stopped", busy, 0);
    endtask

    task automatic test_cont_idle();
        int seen = 0;
        write_word(mk(0, 1, 1, 3'd0, 2'b00, 0, 0, 0));
        if (conv_start) seen++;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (busy || conv_start) seen++;
        end
        check(seen == 0, "R8 no start from cont bit", seen, 0);
    endtask

    task automatic test_cfg_hold();
        write_word(mk(1, 0, 1, 3'd2, 2'b01, 1, 1, 0));
        @(negedge clk);
        write_word(mk(0, 0, 1, 3'd5, 2'b11, 0, 0, 1));
        @(negedge clk);
        check(rate_sel == 3'd2, "R9 rate held", rate_sel, 2);
        check(gain_mult == 4'd2, "R9 gain held", gain_mult, 2);
        check(in_swap && bipolar && !ref_sel, "R9 flags held",
              {in_swap, bipolar, ref_sel}, 6);
    endtask

    task automatic test_gain();
        for (int g = 0; g < 4; g++) begin
            write_word(mk(1, 0, 1, 3'd0, 2'(g), 0, 0, 1));
            @(negedge clk);
            check(gain_mult == (4'd1 << g), "R10 gain decode", gain_mult, 1 << g);
            check(ref_sel, "R10 ref follows start", ref_sel, 1);
        end
    endtask

    task automatic test_read_clear();
        int m;
        write_word(mk(1, 0, 1, 3'd0, 2'b00, 0, 0, 0));
        wait_done(m);
        check(done, "R11 done set", done, 1);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        check(!done, "R11 read clears", done, 0);
        wait_done(m);
        write_word(mk(1, 0, 1, 3'd0, 2'b00, 0, 0, 0));
        @(negedge clk);
        check(!done, "R11 new start clears", done, 0);
        wait_done(m);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_single(3'd0, 17);
        test_single(3'd2, 65);
        test_cont_abort();
        test_power_off();
        test_cont_idle();
        test_cfg_hold();
        test_gain();
        test_read_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule